// File: doc/BRIEF.md
# PWM and Edge-Capture Timer

This block is a single timer that works in one of two modes, chosen by one control bit. In waveform mode, software loads duty values into an eight-entry queue. The counter runs over a programmed period, and the output pin is active while the count is below the current duty value. Each queued duty value stays in force for 1, 4, 8 or 16 periods before the next one is taken. When the queue runs dry, the last value is kept.

In capture mode, the same counter measures the number of clocks between qualifying edges on the input pin. Each measurement is pushed into the same queue, and software drains it. Event flags can be cleared by writing 1. Each flag has an enable, and the enabled flags drive one interrupt line.

Software reaches the block through a small register port with word addresses 0 to 6. The addresses are: 0 control, 1 interrupt enable, 2 flags, 3 queue occupancy, 4 current count, 5 count end, 6 queue data.

Top module: `pwmcap_timer`

## Requirements
- R1: After reset, control, enables and flags read 0, queue occupancy reads 0, and both `pwm_out` and `irq` are low.
- R2: Writing control with bit 1 set empties the queue, zeroes the counter, the flags, the held duty and the repeat count. Bit 1 itself reads back as 0.
- R3: The queue holds 8 entries of 26 bits, and address 3 returns its occupancy. A push while it is full drops the value and sets flag bit 4.
- R4: In waveform mode (control bit 0 = 0, bit 2 = 1), the counter steps from 0 up to count-end minus 1 and then restarts. `pwm_out` is high while the count is below the duty value and control bit 3 is 1. With bit 3 = 0, `pwm_out` stays low.
- R5: Control bit 4 inverts the waveform output while it is enabled.
- R6: Control bits 7:6 set the number of periods per duty value: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16. The first group after a clear uses duty 0. A new value is taken from the queue at the end of each group, and an empty queue holds the last value. In waveform mode, writing address 6 pushes a value.
- R7: In waveform mode, each period end sets flag bit 0 and each duty pop sets flag bit 1.
- R8: In capture mode (control bit 0 = 1), control bits 7:6 select the edges: 0 none, 1 every edge, 2 falling to falling, 3 rising to rising. Each qualifying edge pushes the number of clocks since the previous qualifying edge, restarts the counter and sets flag bit 1. Reading address 6 pops the queue. Edge setting 0 pushes nothing.
- R9: In capture mode, if the count reaches count-end minus 1 with no edge, flag bit 0 is set and the counter wraps to 0.
- R10: While counting, flag bit 2 is set when occupancy is at least 4 in capture mode, or at most 3 in waveform mode.
- R11: Writing 1 to a flag bit clears it, and a flag stays set until then. `irq` is high when any flag is set together with its enable bit at address 1. Flag bit 3 always reads 0.
- R12: With control bit 2 = 0, the counter holds its value and no queue traffic is started by the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the queue at address 6 in capture mode) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cap_in | input | 1 | Capture input pin, asynchronous |
| pwm_out | output | 1 | Waveform output pin |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default 26-bit width and eight-entry queue. At that depth, a burst of ten edges reaches the full queue and the dropped-push path. The half threshold of four sits between the short and long capture runs. Because periods are short (2 to 12 clocks), the bench can count every high cycle over whole groups of 16 repeats. It also checks the hold of the last duty value within a few hundred clocks.

// File: rtl/pwmcap_pkg.sv
// Package: register word addresses and the repeat-code decode shared by
// the timer blocks. Assumes a 3-bit word address on the register port.
package pwmcap_pkg;
    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_IEN   = 3'd1;
    localparam logic [2:0] ADR_FLAGS = 3'd2;
    localparam logic [2:0] ADR_OCC   = 3'd3;
    localparam logic [2:0] ADR_COUNT = 3'd4;
    localparam logic [2:0] ADR_END   = 3'd5;
    localparam logic [2:0] ADR_DATA  = 3'd6;

    localparam int NFLAGS = 5;

    // Last repeat index for a 2-bit repeat code (1/4/8/16 periods).
    function automatic logic [3:0] rep_limit(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd0;
            2'd1:    return 4'd3;
            2'd2:    return 4'd7;
            default: return 4'd15;
        endcase
    endfunction
endpackage

// File: rtl/pwmcap_fifo.sv
// Queue of DEPTH words shared by both timer modes. Pushes into a full
// queue and pops from an empty one are ignored. Assumes DEPTH is a power
// of two and at least 2. Head data is shown without a register stage.
module pwmcap_fifo #(
    parameter int W     = 26,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/pwmcap_edge.sv
// Brings the asynchronous capture pin into the clock domain with two
// flops and flags single-cycle rising and falling edges one stage later.
module pwmcap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [2:0] sh;

    // Synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], pin};
    end

    assign rise = sh[1] & ~sh[2];
    assign fall = ~sh[1] & sh[2];
endmodule

// File: rtl/pwmcap_core.sv
// Counter engine for both modes. Waveform mode: counts period, tracks
// repeats, pulls duty values. Capture mode: qualifies edges, emits the
// interval (count + 1) and restarts. Assumes the queue head is valid
// whenever fifo_empty is low.
module pwmcap_core #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         cap_mode,
    input  logic [1:0]   sel,
    input  logic [W-1:0] cnt_end,
    input  logic [W-1:0] head,
    input  logic         fifo_empty,
    input  logic         cap_in,
    output logic [W-1:0] cnt,
    output logic         pwm_active,
    output logic         push,
    output logic [W-1:0] push_data,
    output logic         pop,
    output logic         ev_cycle,
    output logic         ev_data
);
    import pwmcap_pkg::*;

    logic         rise, fall, qual, wrap, group_end;
    logic [W:0]   nxt;
    logic [W-1:0] duty;
    logic [3:0]   rep;

    pwmcap_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cap_in),
        .rise (rise),
        .fall (fall)
    );

    assign nxt       = {1'b0, cnt} + 1'b1;
    assign wrap      = (nxt >= {1'b0, cnt_end});
    assign group_end = (rep == rep_limit(sel));

    // Edge qualification by selected edge setting.
    always_comb begin
        case (sel)
            2'd1:    qual = rise | fall;
            2'd2:    qual = fall;
            2'd3:    qual = rise;
            default: qual = 1'b0;
        endcase
    end

    // Event and queue strobes for the current cycle.
    always_comb begin
        push       = en & cap_mode & qual;
        push_data  = nxt[W-1:0];
        pop        = en & ~cap_mode & wrap & group_end & ~fifo_empty;
        ev_cycle   = en & wrap & ~(cap_mode & qual);
        ev_data    = cap_mode ? push : pop;
        pwm_active = (cnt < duty);
    end

    // Main counter: restarts on wrap or qualifying edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)            cnt <= '0;
        else if (en) begin
            if ((cap_mode & qual) | wrap) cnt <= '0;
            else                          cnt <= nxt[W-1:0];
        end
    end

    // Repeat tracking and duty reload at group end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rep  <= '0;
            duty <= '0;
        end else if (en && !cap_mode && wrap) begin
            if (group_end) begin
                rep <= '0;
                if (!fifo_empty) duty <= head;
            end else begin
                rep <= rep + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwmcap_timer.sv
// Top of the timer: register port, flag logic and routing of queue
// traffic between bus and engine by mode. Reads are combinational; a
// read strobe at the data address pops the queue in capture mode only.
module pwmcap_timer #(
    parameter int W     = 26,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cap_in,
    output logic        pwm_out,
    output logic        irq
);
    import pwmcap_pkg::*;

    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    logic [7:0]        ctrl;
    logic [NFLAGS-1:0] ien, flags, fset, fclr;
    logic [W-1:0]      cnt_end, cnt, head, core_data, fifo_din;
    logic [CW-1:0]     occ;
    logic              clr, cap_mode, en, full, empty, half;
    logic              bus_push, bus_pop, core_push, core_pop;
    logic              fifo_push, fifo_pop, ev_cycle, ev_data, active;

    assign cap_mode = ctrl[0];
    assign en       = ctrl[2];
    assign clr      = reg_we && (reg_addr == ADR_CTRL) && reg_wdata[1];
    assign bus_push = reg_we && (reg_addr == ADR_DATA) && !cap_mode;
    assign bus_pop  = reg_re && (reg_addr == ADR_DATA) && cap_mode;

    assign fifo_push = cap_mode ? core_push : bus_push;
    assign fifo_din  = cap_mode ? core_data : reg_wdata[W-1:0];
    assign fifo_pop  = cap_mode ? bus_pop : core_pop;
    assign half      = cap_mode ? (occ >= HALF) : (occ < HALF);

    pwmcap_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .push (fifo_push),
        .din  (fifo_din),
        .pop  (fifo_pop),
        .dout (head),
        .count(occ),
        .full (full),
        .empty(empty)
    );

    pwmcap_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .en        (en),
        .cap_mode  (cap_mode),
        .sel       (ctrl[7:6]),
        .cnt_end   (cnt_end),
        .head      (head),
        .fifo_empty(empty),
        .cap_in    (cap_in),
        .cnt       (cnt),
        .pwm_active(active),
        .push      (core_push),
        .push_data (core_data),
        .pop       (core_pop),
        .ev_cycle  (ev_cycle),
        .ev_data   (ev_data)
    );

    // Control, enable and period registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            ien     <= '0;
            cnt_end <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                ADR_CTRL: ctrl    <= reg_wdata[7:0] & 8'hFD;
                ADR_IEN:  ien     <= reg_wdata[NFLAGS-1:0];
                ADR_END:  cnt_end <= reg_wdata[W-1:0];
                default:  ;
            endcase
        end
    end

    // Flag set sources and write-one-to-clear mask.
    always_comb begin
        fset = {fifo_push & full, 1'b0, half & en, ev_data, ev_cycle};
        fclr = (reg_we && reg_addr == ADR_FLAGS) ? reg_wdata[NFLAGS-1:0] : '0;
    end

    // Sticky flags; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) flags <= '0;
        else               flags <= (flags & ~fclr) | fset;
    end

    // Pins.
    assign pwm_out = ctrl[3] & ~cap_mode & (active ^ ctrl[4]);
    assign irq     = |(flags & ien);

    // Read data mux.
    always_comb begin
        case (reg_addr)
            ADR_CTRL:  reg_rdata = 32'(ctrl);
            ADR_IEN:   reg_rdata = 32'(ien);
            ADR_FLAGS: reg_rdata = 32'(flags);
            ADR_OCC:   reg_rdata = 32'(occ);
            ADR_COUNT: reg_rdata = 32'(cnt);
            ADR_END:   reg_rdata = 32'(cnt_end);
            ADR_DATA:  reg_rdata = 32'(head);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwmcap_timer_chk.sv
// Property checker for pwmcap_timer, attached by the bind at the end.
module pwmcap_timer_chk #(
    parameter int W     = 26,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [7:0]    ctrl,
    input logic [4:0]    flags,
    input logic [4:0]    ien,
    input logic [CW-1:0] occ,
    input logic [W-1:0]  cnt,
    input logic          pwm_out,
    input logic          irq
);
    logic clr_wr;
    assign clr_wr = reg_we && reg_addr == 3'd0 && reg_wdata[1];

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    p_clear_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (occ == '0 && cnt == '0 && flags == '0));

    p_out_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[3] |-> !pwm_out);

    p_count_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[2] && !clr_wr) |=> $stable(cnt));

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !clr_wr && !(reg_we && reg_addr == 3'd2 && reg_wdata[1]))
        |=> flags[1]);

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

bind pwmcap_timer pwmcap_timer_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .ctrl     (ctrl),
    .flags    (flags),
    .ien      (ien),
    .occ      (occ),
    .cnt      (cnt),
    .pwm_out  (pwm_out),
    .irq      (irq)
);

// File: tb/pwmcap_timer_test.sv
module pwmcap_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_in = 1'b0;
    logic        pwm_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int duty_q [8];
    int h_q [8];
    int l_q [8];
    int exp_q [16];

    always #2 clk = ~clk;   // 250 MHz

    pwmcap_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 d = int'(reg_rdata);
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    // Periods per duty value for a repeat code.
    function automatic int reps(input int code);
        return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 16;
    endfunction

    // Expected high cycles of the non-inverted waveform over whole periods.
    function automatic int pwm_high(input int e, input int n, input int k, input int periods);
        int sum = 0;
        for (int p = 0; p < periods; p++) begin
            int g = p / n;
            int d = 0;
            if (g > 0 && k > 0) d = duty_q[((g < k) ? g : k) - 1];
            sum += (d < e) ? d : e;
        end
        return sum;
    endfunction

    // Load k duties, start, and count output-high cycles (R4, R5, R6).
    task automatic pwm_run(input int e, input int code, input int k, input int pol,
                           input int oen, input int periods, output int high);
        wr(3'd0, 2);
        wr(3'd5, e);
        for (int i = 0; i < k; i++) wr(3'd6, duty_q[i]);
        wr(3'd0, 4 | (oen << 3) | (pol << 4) | (code << 6));
        high = 0;
        for (int i = 0; i < e * periods; i++) begin
            #1 high += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    // Capture run with np pulses; fills exp_q, returns number of pushes (R8).
    task automatic cap_run(input int mode, input int np, output int npush);
        cap_in = 1'b0;
        wr(3'd0, 2);
        wr(3'd5, 1000);
        wr(3'd0, 5 | (mode << 6));
        repeat (5) @(negedge clk);
        for (int i = 0; i < np; i++) begin
            cap_in = 1'b1;
            repeat (h_q[i]) @(negedge clk);
            cap_in = 1'b0;
            repeat (l_q[i]) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        npush = 0;
        if (mode == 3) begin
            npush = np;
            for (int i = 1; i < np; i++) exp_q[i] = h_q[i-1] + l_q[i-1];
        end else if (mode == 2) begin
            npush = np;
            for (int i = 1; i < np; i++) exp_q[i] = l_q[i-1] + h_q[i];
        end else if (mode == 1) begin
            npush = 2 * np;
            for (int j = 1; j < 2 * np; j++)
                exp_q[j] = (j % 2 == 1) ? h_q[(j-1)/2] : l_q[j/2-1];
        end
    endtask

    initial begin
        int v, v2, hi, np, exp_h;
        void'($urandom(32'd20240715));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 chk("R1 pwm_out", int'(pwm_out), 0);
        chk("R1 irq", int'(irq), 0);
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd2, v); chk("R1 flags", v, 0);
        rd(3'd3, v); chk("R1 occupancy", v, 0);

        // R4/R6: period 10, one period per value, duties 3 then 7 held
        duty_q[0] = 3; duty_q[1] = 7;
        pwm_run(10, 0, 2, 0, 1, 4, hi);
        chk("R4 R6 high cycles", hi, 17);
        rd(3'd2, v); chk("R7 cycle and pop flags", v & 3, 3);

        // R6: four periods per value
        duty_q[0] = 2; duty_q[1] = 4;
        pwm_run(5, 1, 2, 0, 1, 12, hi);
        chk("R6 repeat 4", hi, 24);
        // R5: inverted polarity
        pwm_run(5, 1, 2, 1, 1, 12, hi);
        chk("R5 polarity", hi, 36);
        // R4: output disabled
        pwm_run(5, 0, 2, 0, 0, 8, hi);
        chk("R4 output off", hi, 0);
        // R10: waveform mode, low occupancy
        rd(3'd2, v); chk("R10 half in waveform mode", (v >> 2) & 1, 1);

        // R4 R5 R6: random configurations
        for (int it = 0; it < 6; it++) begin
            int e = $urandom_range(12, 2);
            int code = $urandom_range(3, 0);
            int k = $urandom_range(5, 0);
            int pol = $urandom_range(1, 0);
            int n = reps(code);
            int periods = n * (k + 1) + $urandom_range(3, 0);
            for (int i = 0; i < k; i++) duty_q[i] = $urandom_range(e + 2, 0);
            pwm_run(e, code, k, pol, 1, periods, hi);
            exp_h = pwm_high(e, n, k, periods);
            if (pol != 0) exp_h = e * periods - exp_h;
            chk("R6 random waveform", hi, exp_h);
        end

        // R8: rising-to-rising, random intervals; R10 half flag in capture
        for (int i = 0; i < 8; i++) begin
            h_q[i] = $urandom_range(9, 2);
            l_q[i] = $urandom_range(9, 2);
        end
        cap_run(3, 5, np);
        rd(3'd3, v); chk("R8 rising count", v, np);
        rd(3'd2, v); chk("R10 half in capture", (v >> 2) & 1, 1);
        chk("R11 flag bit 3 zero", (v >> 3) & 1, 0);
        for (int i = 0; i < np; i++) begin
            rd(3'd6, v);
            if (i > 0) chk("R8 rising interval", v, exp_q[i]);
        end
        rd(3'd3, v); chk("R8 drained by reads", v, 0);

        // R8: falling-to-falling
        cap_run(2, 4, np);
        rd(3'd3, v); chk("R8 falling count", v, np);
        for (int i = 0; i < np; i++) begin
            rd(3'd6, v);
            if (i > 0) chk("R8 falling interval", v, exp_q[i]);
        end

        // R8: every edge
        cap_run(1, 3, np);
        rd(3'd3, v); chk("R8 both count", v, np);
        rd(3'd2, v); chk("R8 data flag", (v >> 1) & 1, 1);
        for (int i = 0; i < np; i++) begin
            rd(3'd6, v);
            if (i > 0) chk("R8 both interval", v, exp_q[i]);
        end

        // R8: edge setting none
        cap_run(0, 3, np);
        rd(3'd3, v); chk("R8 no edges pushed", v, 0);

        // R3: ten pushes into eight entries
        cap_run(1, 5, np);
        rd(3'd3, v); chk("R3 occupancy capped", v, 8);
        rd(3'd2, v); chk("R3 overflow flag", (v >> 4) & 1, 1);

        // R2: clear
        wr(3'd0, 2);
        rd(3'd3, v); chk("R2 queue emptied", v, 0);
        rd(3'd2, v); chk("R2 flags cleared", v, 0);
        rd(3'd4, v); chk("R2 counter zero", v, 0);
        rd(3'd0, v); chk("R2 clear bit reads 0", v & 2, 0);

        // R9: timeout in capture mode with no edges
        wr(3'd5, 20);
        wr(3'd0, 5);
        repeat (25) @(negedge clk);
        rd(3'd2, v); chk("R9 timeout flag", v & 1, 1);
        rd(3'd4, v); chk("R9 count wrapped", int'(v < 20), 1);

        // R12: hold when disabled
        wr(3'd0, 1);
        rd(3'd4, v);
        repeat (10) @(negedge clk);
        rd(3'd4, v2); chk("R12 counter holds", v2, v);

        // R11: enable, interrupt, write-one-to-clear
        #1 chk("R11 irq masked", int'(irq), 0);
        wr(3'd1, 1);
        #1 chk("R11 irq raised", int'(irq), 1);
        wr(3'd2, 2);
        rd(3'd2, v); chk("R11 other flag kept", v & 1, 1);
        wr(3'd2, 1);
        rd(3'd2, v); chk("R11 flag cleared", v, 0);
        #1 chk("R11 irq dropped", int'(irq), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule